// File: doc/BRIEF.md
# Serial Converter Control Front End

This block is the device-side digital control logic of a 12-bit successive-approximation converter that is reached over a four-wire serial link. The link has an active-low select, a serial clock, a data input and a data output, plus a strobe output. Every serial pin is oversampled in the block's system clock domain. A serial clock edge counts as an event in the system clock cycle that first sees its new level.

With select low, the block discards zero bits until a one arrives. That one opens an 8-bit control word. The word is decoded into the input routing, the polarity, the input mode and a two-bit mode field that picks power-down or conversion. For an externally clocked conversion, the block runs the sequence from the serial clock. It tracks the input, then holds it, gives one strobe period, and then makes twelve comparator decisions. Each decision is shipped on data-out as it is made, so the most significant bit comes first. The analog side is modelled by a trial code output and a comparator input: the comparator reports high when the sampled input is at or above the trial code.

Top module: `adc_serial_ctl`

## Requirements
- R1: With select low and no word open, zeros sampled on rising serial clock edges are ignored. The first one sampled becomes bit 7 of the control word, and the next seven rising edges supply bits 6 down to 0.
- R2: The control word fields are: bits 6:4 the selector s[2:0], bit 3 polarity (1 = unipolar), bit 2 input mode (1 = single-ended), bits 1:0 the mode. The positive route is mux_pos = {s[1], s[0], s[2]}. Single-ended mode sets neg_gnd=1 and mux_neg=0. Differential mode sets neg_gnd=0 and mux_neg = mux_pos XOR 1. After reset the mode is 11, with unipolar single-ended routing to input 0.
- R3: track rises on the falling serial edge after the fifth control bit and falls on the falling edge after the eighth control bit.
- R4: In mode 11, strobe goes high on the falling edge after the eighth control bit and low on the next falling edge.
- R5: In mode 11, the 12 result bits appear on dout MSB first, one per falling edge, on falling edges 9 to 20 counted from the start bit. A unipolar result is the straight binary input code.
- R6: A bipolar result is in two's complement, which is the input code with its MSB inverted.
- R7: On the falling edge after the last result bit, dout goes low. A new start bit is then accepted without deselecting.
- R8: Modes 00 and 01 set asleep on the falling edge after the eighth bit. Mode 10 leaves asleep clear. None of the three modes produces a strobe or any result bits. pwr_mode reports the last decoded mode.
- R9: A falling edge on select clears asleep.
- R10: dout_oe and strobe_oe are low while select is high, and high while select is low.
- R11: Raising select mid-frame aborts the frame: track, strobe and dout go low, and the next frame starts over by hunting for a start bit.
- R12: data-in is ignored from the strobe until the last result bit, and it starts no new control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data input |
| cmp_hi | input | 1 | Comparator: input at or above trial code |
| dout | output | 1 | Serial result output |
| dout_oe | output | 1 | Drive enable for dout |
| strobe | output | 1 | Strobe before the MSB |
| strobe_oe | output | 1 | Drive enable for strobe |
| trial | output | 12 | Trial code presented to the comparator |
| track | output | 1 | Track (1) or hold (0) control |
| mux_pos | output | 3 | Positive input route |
| mux_neg | output | 3 | Negative input route when differential |
| neg_gnd | output | 1 | Negative side tied to ground |
| unipolar | output | 1 | Decoded polarity |
| pwr_mode | output | 2 | Last decoded mode field |
| asleep | output | 1 | Power-down state |

## Verification
A rising edge on select and a falling serial clock edge can land in the same system clock cycle. When that happens, the abort competes with a track change, a strobe step or a shifted result bit. The bench provokes this by changing select and the serial clock together. It does so once in the middle of the control word and once in the middle of the result. Each time it requires track, strobe and dout low with both enables off. A following frame must then restart from start-bit hunting and deliver a correct result.

// File: rtl/adcif_pkg.sv
package adcif_pkg;

    typedef enum logic [1:0] {
        PWR_FULL_OFF = 2'b00,
        PWR_FAST_OFF = 2'b01,
        CONV_INT_CLK = 2'b10,
        CONV_EXT_CLK = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [2:0] sel;
        logic       unipolar;
        logic       single;
        pwr_mode_e  mode;
    } ctl_word_t;

    typedef struct packed {
        logic [2:0] pos;
        logic [2:0] neg;
        logic       neg_gnd;
    } mux_route_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'b00,
        SQ_STROBE = 2'b01,
        SQ_BITS   = 2'b10
    } seq_state_e;

    localparam ctl_word_t CTL_RESET = '{sel: 3'd0, unipolar: 1'b1,
                                        single: 1'b1, mode: CONV_EXT_CLK};

    // Field layout below bit 7 (the start bit)
    function automatic ctl_word_t unpack_ctl(input logic [6:0] b);
        ctl_word_t r;
        r.sel      = b[6:4];
        r.unipolar = b[3];
        r.single   = b[2];
        r.mode     = pwr_mode_e'(b[1:0]);
        return r;
    endfunction

    // Selector is interleaved: even inputs first, then odd ones
    function automatic mux_route_t route_of(input ctl_word_t c);
        mux_route_t m;
        m.pos     = {c.sel[1], c.sel[0], c.sel[2]};
        m.neg     = c.single ? 3'd0 : (m.pos ^ 3'd1);
        m.neg_gnd = c.single;
        return m;
    endfunction

    function automatic logic is_sleep(input pwr_mode_e m);
        return (m == PWR_FULL_OFF) || (m == PWR_FAST_OFF);
    endfunction

endpackage

// File: rtl/adcif_serial_edges.sv
module adcif_serial_edges (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    output logic sc_rise,
    output logic sc_fall,
    output logic cs_fall,
    output logic oe
);
    logic sclk_d;
    logic cs_d;
    logic oe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
            oe_q   <= 1'b0;
        end else begin
            sclk_d <= sclk;
            cs_d   <= cs_n;
            oe_q   <= ~cs_n;
        end
    end

    assign sc_rise = sclk & ~sclk_d;
    assign sc_fall = ~sclk & sclk_d;
    assign cs_fall = ~cs_n & cs_d;
    assign oe      = oe_q;

    // R10
    oe_off_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> !oe);

endmodule

// File: rtl/adcif_ctl_rx.sv
module adcif_ctl_rx #(
    parameter int CTL_W    = 8,
    parameter int TRACK_AT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sc_rise,
    input  logic             sc_fall,
    input  logic             din,
    input  logic             hunt_ok,
    output logic             track,
    output logic             byte_done,
    output logic [CTL_W-1:0] byte_q
);
    localparam int CW = $clog2(CTL_W + 1);

    logic [CW-1:0]    cnt_q;
    logic [CTL_W-1:0] sh_q;
    logic             track_q;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sh_q    <= '0;
            track_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (cs_n) begin
                cnt_q   <= '0;
                track_q <= 1'b0;
            end else if (sc_rise) begin
                if (cnt_q == '0) begin
                    if (din && hunt_ok) begin
                        cnt_q <= CW'(1);
                        sh_q  <= {{(CTL_W-1){1'b0}}, 1'b1};
                    end
                end else if (cnt_q < CW'(CTL_W)) begin
                    sh_q  <= {sh_q[CTL_W-2:0], din};
                    cnt_q <= cnt_q + CW'(1);
                end
            end else if (sc_fall) begin
                if (cnt_q == CW'(TRACK_AT)) begin
                    track_q <= 1'b1;
                end
                if (cnt_q == CW'(CTL_W)) begin
                    track_q <= 1'b0;
                    done_q  <= 1'b1;
                    cnt_q   <= '0;
                end
            end
        end
    end

    assign track     = track_q;
    assign byte_done = done_q;
    assign byte_q    = sh_q;

    // R3
    track_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(track_q) |-> ($past(cnt_q) == CW'(TRACK_AT)) && $past(sc_fall));

    // R1
    zero_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0 && sc_rise && !din && !cs_n) |=> (cnt_q == '0));

    // R11
    abort_rx_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!track_q && cnt_q == '0));

endmodule

// File: rtl/adcif_sar_seq.sv
module adcif_sar_seq
    import adcif_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sc_fall,
    input  logic             go,
    input  logic             bipolar,
    input  logic             cmp_hi,
    output logic             dout,
    output logic             strobe,
    output logic             busy,
    output logic [RES_W-1:0] trial
);
    localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

    seq_state_e       state_q;
    logic [RES_W-1:0] res_q;
    logic [RES_W-1:0] mask_q;
    logic             bip_q;
    logic             dout_q;
    logic             strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_IDLE;
            res_q    <= '0;
            mask_q   <= '0;
            bip_q    <= 1'b0;
            dout_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else if (cs_n) begin
            state_q  <= SQ_IDLE;
            mask_q   <= '0;
            dout_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else if (go) begin
            state_q  <= SQ_STROBE;
            res_q    <= '0;
            mask_q   <= TOP_BIT;
            bip_q    <= bipolar;
            dout_q   <= 1'b0;
            strobe_q <= 1'b1;
        end else if (sc_fall) begin
            if (state_q == SQ_IDLE) begin
                dout_q <= 1'b0;
            end else begin
                strobe_q <= 1'b0;
                if (cmp_hi) begin
                    res_q <= res_q | mask_q;
                end
                dout_q <= cmp_hi ^ (bip_q & mask_q[RES_W-1]);
                mask_q <= mask_q >> 1;
                state_q <= mask_q[0] ? SQ_IDLE : SQ_BITS;
            end
        end
    end

    assign trial  = res_q | mask_q;
    assign dout   = dout_q;
    assign strobe = strobe_q;
    assign busy   = (state_q != SQ_IDLE);

    // R5
    mask_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mask_q));

    // R4
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && sc_fall && !cs_n && !go) |=> !strobe_q);

    // R11
    abort_seq_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!strobe_q && !dout_q && state_q == SQ_IDLE));

    // R7
    tail_low_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_IDLE && sc_fall && !cs_n && !go) |=> !dout_q);

endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl
    import adcif_pkg::*;
#(
    parameter int RES_W    = 12,
    parameter int CTL_W    = 8,
    parameter int TRACK_AT = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             cmp_hi,
    output logic             dout,
    output logic             dout_oe,
    output logic             strobe,
    output logic             strobe_oe,
    output logic [RES_W-1:0] trial,
    output logic             track,
    output logic [2:0]       mux_pos,
    output logic [2:0]       mux_neg,
    output logic             neg_gnd,
    output logic             unipolar,
    output logic [1:0]       pwr_mode,
    output logic             asleep
);
    logic             sc_rise;
    logic             sc_fall;
    logic             cs_fall;
    logic             oe;
    logic             byte_done;
    logic [CTL_W-1:0] byte_q;
    logic             busy;
    logic             go;
    ctl_word_t        new_cfg;
    ctl_word_t        cfg_q;
    mux_route_t       route;
    logic             asleep_q;

    adcif_serial_edges u_edges (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .sc_rise (sc_rise),
        .sc_fall (sc_fall),
        .cs_fall (cs_fall),
        .oe      (oe)
    );

    adcif_ctl_rx #(
        .CTL_W    (CTL_W),
        .TRACK_AT (TRACK_AT)
    ) u_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_n      (cs_n),
        .sc_rise   (sc_rise),
        .sc_fall   (sc_fall),
        .din       (din),
        .hunt_ok   (~busy),
        .track     (track),
        .byte_done (byte_done),
        .byte_q    (byte_q)
    );

    assign new_cfg = unpack_ctl(byte_q[6:0]);
    assign go      = byte_done && (new_cfg.mode == CONV_EXT_CLK);

    adcif_sar_seq #(
        .RES_W (RES_W)
    ) u_sar (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sc_fall (sc_fall),
        .go      (go),
        .bipolar (~new_cfg.unipolar),
        .cmp_hi  (cmp_hi),
        .dout    (dout),
        .strobe  (strobe),
        .busy    (busy),
        .trial   (trial)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CTL_RESET;
            asleep_q <= 1'b0;
        end else begin
            if (cs_fall) begin
                asleep_q <= 1'b0;
            end
            if (byte_done) begin
                cfg_q <= new_cfg;
                if (is_sleep(new_cfg.mode)) begin
                    asleep_q <= 1'b1;
                end
            end
        end
    end

    assign route     = route_of(cfg_q);
    assign mux_pos   = route.pos;
    assign mux_neg   = route.neg;
    assign neg_gnd   = route.neg_gnd;
    assign unipolar  = cfg_q.unipolar;
    assign pwr_mode  = cfg_q.mode;
    assign asleep    = asleep_q;
    assign dout_oe   = oe;
    assign strobe_oe = oe;

    // R9
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        cs_fall |=> !asleep_q);

    // R8
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        asleep_q |-> !strobe);

    // R10
    enables_off_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (!dout_oe && !strobe_oe));

    // R12
    busy_no_word_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !byte_done);

endmodule

// File: tb/test_adc_serial_ctl.sv
`timescale 1ns/1ps
module test_adc_serial_ctl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        din = 1'b0;
    logic [11:0] ana = 12'h000;
    logic        cmp_hi;
    logic        dout, dout_oe, strobe, strobe_oe, track, neg_gnd, unipolar, asleep;
    logic [11:0] trial;
    logic [2:0]  mux_pos, mux_neg;
    logic [1:0]  pwr_mode;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    // analog model: comparator high when the input code is at or above the trial
    assign cmp_hi = (ana >= trial);

    adc_serial_ctl i_adc_serial_ctl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din), .cmp_hi(cmp_hi),
        .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .strobe_oe(strobe_oe),
        .trial(trial), .track(track), .mux_pos(mux_pos), .mux_neg(mux_neg),
        .neg_gnd(neg_gnd), .unipolar(unipolar), .pwr_mode(pwr_mode), .asleep(asleep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic d);
        din = d;
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
        idle(4);
    endtask

    task automatic select_on();
        cs_n = 1'b0;
        idle(4);
    endtask

    task automatic select_off();
        cs_n = 1'b1;
        idle(4);
    endtask

    // one externally clocked conversion inside an open frame
    task automatic run_conv(input string tag, input logic [7:0] ctl, input logic [11:0] code,
                            input int zeros, input logic din_hi);
        logic [11:0] exp;
        ana = code;
        for (int i = 0; i < zeros; i++) begin
            pulse(1'b0);
            chk({tag, " R1 zero ignored track"}, track, 1'b0);
        end
        for (int i = 7; i >= 0; i--) begin
            pulse(ctl[i]);
            if (i == 4) chk({tag, " R3 no track after bit 4"}, track, 1'b0);
            if (i == 3) chk({tag, " R3 track after bit 5"}, track, 1'b1);
            if (i == 0) begin
                chk({tag, " R3 hold after bit 8"}, track, 1'b0);
                chk({tag, " R4 strobe high"}, strobe, 1'b1);
            end
        end
        exp = ctl[3] ? code : (code ^ 12'h800);
        for (int b = 11; b >= 0; b--) begin
            pulse(din_hi);
            chk({tag, ctl[3] ? " R5 result bit" : " R6 result bit"}, dout, exp[b]);
            chk({tag, " R4 strobe low"}, strobe, 1'b0);
        end
        pulse(1'b0);
        chk({tag, " R7 dout low after LSB"}, dout, 1'b0);
    endtask

    task automatic t_reset();
        chk("R10 reset dout_oe", dout_oe, 1'b0);
        chk("R10 reset strobe_oe", strobe_oe, 1'b0);
        chk("R8 reset asleep", asleep, 1'b0);
        chk("R2 reset mode", pwr_mode, 2'b11);
        chk("R2 reset route", {mux_pos, neg_gnd, unipolar}, {3'd0, 1'b1, 1'b1});
    endtask

    task automatic t_unipolar();
        select_on();
        chk("R10 enables on", {dout_oe, strobe_oe}, 2'b11);
        run_conv("uni", 8'hFF, 12'hA5C, 3, 1'b0);
        chk("R2 pos route sel 111", mux_pos, 3'd7);
        chk("R2 single-ended gnd", neg_gnd, 1'b1);
        select_off();
        chk("R10 enables off", {dout_oe, strobe_oe}, 2'b00);
    endtask

    task automatic t_bipolar();
        select_on();
        run_conv("bip", 8'hC3, 12'h3F0, 0, 1'b0);
        chk("R2 diff pos sel 100", mux_pos, 3'd1);
        chk("R2 diff neg", {mux_neg, neg_gnd}, {3'd0, 1'b0});
        chk("R2 polarity", unipolar, 1'b0);
        select_off();
    endtask

    task automatic t_extremes_restart();
        select_on();
        run_conv("full", 8'h9F, 12'hFFF, 1, 1'b0);
        chk("R2 pos route sel 001", mux_pos, 3'd2);
        run_conv("R7 restart zero", 8'h9F, 12'h000, 0, 1'b0);
        run_conv("R7 restart bip zero", 8'hE7, 12'h800, 2, 1'b0);
        chk("R2 pos route sel 110", {mux_pos, neg_gnd}, {3'd5, 1'b1});
        select_off();
    endtask

    task automatic t_din_ignored();
        select_on();
        run_conv("R12 din high", 8'hAF, 12'h5A3, 0, 1'b1);
        chk("R12 mode kept", pwr_mode, 2'b11);
        chk("R12 route kept", mux_pos, 3'd4);
        select_off();
    endtask

    task automatic t_abort();
        select_on();
        ana = 12'h123;
        for (int i = 7; i >= 2; i--) pulse(i[0] ? 1'b1 : 1'b1);
        chk("R11 track before abort", track, 1'b1);
        din = 1'b1;
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
        cs_n = 1'b1;
        idle(4);
        chk("R11 abort track", track, 1'b0);
        chk("R11 abort enables", {dout_oe, strobe_oe}, 2'b00);
        chk("R11 abort strobe", strobe, 1'b0);
        select_on();
        run_conv("R11 after ctl abort", 8'hFB, 12'h7FE, 1, 1'b0);
        select_off();
        select_on();
        for (int i = 7; i >= 0; i--) pulse(i == 7 ? 1'b1 : 1'b1);
        for (int i = 0; i < 3; i++) pulse(1'b0);
        din = 1'b0;
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
        cs_n = 1'b1;
        idle(4);
        chk("R11 abort result dout", dout, 1'b0);
        chk("R11 abort result enables", {dout_oe, strobe_oe}, 2'b00);
        select_on();
        for (int i = 0; i < 4; i++) begin
            pulse(1'b0);
            chk("R11 no resume", {dout, strobe}, 2'b00);
        end
        run_conv("R11 after result abort", 8'hFF, 12'h001, 0, 1'b0);
        select_off();
    endtask

    task automatic t_power();
        select_on();
        for (int i = 7; i >= 0; i--) pulse(8'h8C >> i);
        chk("R8 full off asleep", asleep, 1'b1);
        chk("R8 full off no strobe", strobe, 1'b0);
        chk("R8 mode 00", pwr_mode, 2'b00);
        pulse(1'b0);
        chk("R8 no result", dout, 1'b0);
        select_off();
        chk("R8 asleep held", asleep, 1'b1);
        select_on();
        chk("R9 wake on select", asleep, 1'b0);
        for (int i = 7; i >= 0; i--) pulse(8'h8D >> i);
        chk("R8 fast off asleep", asleep, 1'b1);
        chk("R8 mode 01", pwr_mode, 2'b01);
        select_off();
        select_on();
        chk("R9 wake again", asleep, 1'b0);
        for (int i = 7; i >= 0; i--) pulse(8'h8E >> i);
        chk("R8 mode 10", pwr_mode, 2'b10);
        chk("R8 mode 10 awake", asleep, 1'b0);
        chk("R8 mode 10 no strobe", strobe, 1'b0);
        pulse(1'b0);
        chk("R8 mode 10 no result", dout, 1'b0);
        select_off();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_unipolar();
        t_bipolar();
        t_extremes_restart();
        t_din_ignored();
        t_abort();
        t_power();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule